// File: doc/BRIEF.md
# Streaming Spike Bin Counter

The block turns a serialized stream of one-bit spike indicators into per-neuron bin counts as the bits arrive. Every time step carries one bit per neuron, delivered neuron by neuron in a fixed order (neuron 0 first) before the next time step begins. A small count memory with one entry per neuron adds each arriving bit to that neuron's running total. No input frame is ever buffered.

A bin spans a fixed number of consecutive time steps, and bins do not overlap. On the closing time step of a bin, each neuron's total (stored count plus the bit that arrives now) is emitted with its neuron index and bin index, and its memory entry returns to zero. A frame holds a fixed number of bins. After the last record of a frame has left the block, a one-cycle frame-done pulse is raised, and the bin index starts again at zero.

Top module: `spike_bin_counter`

## Requirements
- R1: A synchronous active-high reset clears every index and count: while reset is high and in the cycle after, out_valid and frame_done are 0 and in_ready is 1. The first bin after reset counts only bits accepted after reset.
- R2: Accepted input beats are assigned to neurons in the order 0, 1, ..., NEURONS-1 and then back to 0, and each full pass over the neurons is one time step.
- R3: The count emitted for a neuron equals the number of 1 bits accepted for that neuron in the STEPS time steps of the bin.
- R4: A record is presented on out_valid in the cycle after the clock edge that accepts a beat of the closing time step of a bin, with out_neuron set to that beat's neuron. Per bin, records appear in neuron order.
- R5: After a neuron's record is produced, its count starts again from zero for the next bin.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_count, out_neuron and out_bin keep their values.
- R7: out_bin counts 0 to BINS-1 over a frame and returns to 0 in the next frame.
- R8: frame_done is 1 for exactly the one cycle after the handshake of the record with out_neuron = NEURONS-1 and out_bin = BINS-1, and is 0 in every other cycle.
- R9: Cycles with in_valid low change no count and no index.
- R10: A neuron that spikes in every step of a bin yields the count STEPS, with no wrap-around of the count field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A spike bit is offered |
| in_bit | input | 1 | Spike indicator for the current neuron and time step (1 = spike) |
| in_ready | output | 1 | The offered bit is taken on this edge |
| out_ready | input | 1 | The consumer takes the current record |
| out_valid | output | 1 | A bin record is presented |
| out_count | output | clog2(STEPS+1) | Number of spikes in the bin |
| out_neuron | output | clog2(NEURONS) | Neuron index of the record |
| out_bin | output | clog2(BINS) | Bin index within the frame |
| frame_done | output | 1 | One-cycle pulse after the frame's last record |

## Verification
The hardest condition to reach from the ports is a consumer that stalls exactly when a bin closes. Here the record for one neuron must stay frozen while the next neuron's bit is already waiting at the input. The stimulus holds out_ready low across the first closing beat of a frame and watches the record and in_ready over several cycles before it releases the consumer. A second hard case is a reset that arrives partway through a bin while counts are not zero. A run of spikes is fed, reset is applied, and then a silent frame must yield only zero counts, starting again at neuron 0 of bin 0.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Width of an index over n items (at least one bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width that holds a count from 0 up to steps inclusive.
    function automatic int unsigned cnt_w(input int unsigned steps);
        return $clog2(steps + 1);
    endfunction

    // Position of the current time step inside its bin.
    typedef enum logic {
        STEP_ACCUM = 1'b0,
        STEP_CLOSE = 1'b1
    } step_kind_e;

endpackage

// File: rtl/sbc_sequencer.sv
module sbc_sequencer
    import sbc_pkg::*;
#(
    parameter int unsigned NEURONS = 8,
    parameter int unsigned STEPS   = 3,
    parameter int unsigned BINS    = 4,
    parameter int unsigned NW      = idx_w(NEURONS),
    parameter int unsigned BW      = idx_w(BINS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [NW-1:0] neuron,
    output logic [BW-1:0] bin,
    output step_kind_e    kind
);
    localparam int unsigned SW = idx_w(STEPS);
    localparam logic [NW-1:0] N_LAST = NW'(NEURONS - 1);
    localparam logic [SW-1:0] S_LAST = SW'(STEPS - 1);
    localparam logic [BW-1:0] B_LAST = BW'(BINS - 1);

    logic [SW-1:0] step;

    always_ff @(posedge clk) begin
        if (rst) begin
            neuron <= '0;
            step   <= '0;
            bin    <= '0;
        end else if (adv) begin
            if (neuron == N_LAST) begin
                neuron <= '0;
                if (step == S_LAST) begin
                    step <= '0;
                    bin  <= (bin == B_LAST) ? '0 : bin + 1'b1;
                end else begin
                    step <= step + 1'b1;
                end
            end else begin
                neuron <= neuron + 1'b1;
            end
        end
    end

    assign kind = (step == S_LAST) ? STEP_CLOSE : STEP_ACCUM;

    // R2: neuron index stays in range and wraps after the last neuron
    a_r2_neuron_range: assert property (@(posedge clk) disable iff (rst)
        neuron <= N_LAST);
    a_r2_neuron_wrap: assert property (@(posedge clk) disable iff (rst)
        adv && (neuron == N_LAST) |=> neuron == '0);
    // R9: no advance without an accepted beat
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(neuron) && $stable(step) && $stable(bin));
    // R7: bin index never leaves the frame
    a_r7_bin_range: assert property (@(posedge clk) disable iff (rst)
        bin <= B_LAST);

endmodule

// File: rtl/sbc_count_mem.sv
module sbc_count_mem
    import sbc_pkg::*;
#(
    parameter int unsigned NEURONS = 8,
    parameter int unsigned STEPS   = 3,
    parameter int unsigned NW      = idx_w(NEURONS),
    parameter int unsigned CW      = cnt_w(STEPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [NW-1:0] addr,
    input  logic          bit_in,
    input  step_kind_e    kind,
    output logic [CW-1:0] sum
);
    logic [CW-1:0] cnt [NEURONS];
    logic [CW-1:0] stored;

    always_comb begin
        stored = '0;
        for (int i = 0; i < NEURONS; i++) begin
            if (addr == NW'(i)) stored = cnt[i];
        end
    end

    assign sum = stored + CW'(bit_in);

    for (genvar g = 0; g < NEURONS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (wr_en && (addr == NW'(g))) begin
                cnt[g] <= (kind == STEP_CLOSE) ? '0 : sum;
            end
        end

        // R5/R10: a stored entry never exceeds STEPS-1, since it is cleared at close
        a_r10_entry_bound: assert property (@(posedge clk) disable iff (rst)
            cnt[g] <= CW'(STEPS - 1));
        // R5: a closing write leaves the entry empty
        a_r5_cleared: assert property (@(posedge clk) disable iff (rst)
            wr_en && (addr == NW'(g)) && (kind == STEP_CLOSE) |=> cnt[g] == '0);
    end

endmodule

// File: rtl/sbc_out_stage.sv
module sbc_out_stage
    import sbc_pkg::*;
#(
    parameter int unsigned NEURONS = 8,
    parameter int unsigned STEPS   = 3,
    parameter int unsigned BINS    = 4,
    parameter int unsigned NW      = idx_w(NEURONS),
    parameter int unsigned BW      = idx_w(BINS),
    parameter int unsigned CW      = cnt_w(STEPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] count_in,
    input  logic [NW-1:0] neuron_in,
    input  logic [BW-1:0] bin_in,
    input  logic          out_ready,
    output logic          space,
    output logic          out_valid,
    output logic [CW-1:0] out_count,
    output logic [NW-1:0] out_neuron,
    output logic [BW-1:0] out_bin,
    output logic          frame_done
);
    localparam logic [NW-1:0] N_LAST = NW'(NEURONS - 1);
    localparam logic [BW-1:0] B_LAST = BW'(BINS - 1);

    logic last_rec;

    assign space    = !out_valid || out_ready;
    assign last_rec = (out_neuron == N_LAST) && (out_bin == B_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_count  <= '0;
            out_neuron <= '0;
            out_bin    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= out_valid && out_ready && last_rec;
            if (load) begin
                out_valid  <= 1'b1;
                out_count  <= count_in;
                out_neuron <= neuron_in;
                out_bin    <= bin_in;
            end else if (out_ready) begin
                out_valid  <= 1'b0;
            end
        end
    end

    // R6: a stalled record is held unchanged
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_count)
                                    && $stable(out_neuron) && $stable(out_bin));
    // R6: no new record is loaded over a stalled one
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !load);

endmodule

// File: rtl/spike_bin_counter.sv
module spike_bin_counter
    import sbc_pkg::*;
#(
    parameter int unsigned NEURONS = 8,
    parameter int unsigned STEPS   = 3,
    parameter int unsigned BINS    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_bit,
    output logic                     in_ready,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [cnt_w(STEPS)-1:0]  out_count,
    output logic [idx_w(NEURONS)-1:0] out_neuron,
    output logic [idx_w(BINS)-1:0]   out_bin,
    output logic                     frame_done
);
    localparam int unsigned NW = idx_w(NEURONS);
    localparam int unsigned BW = idx_w(BINS);
    localparam int unsigned CW = cnt_w(STEPS);

    logic          accept;
    logic          space;
    logic [NW-1:0] cur_neuron;
    logic [BW-1:0] cur_bin;
    step_kind_e    cur_kind;
    logic [CW-1:0] sum;

    assign in_ready = space;
    assign accept   = in_valid && space;

    sbc_sequencer #(
        .NEURONS (NEURONS),
        .STEPS   (STEPS),
        .BINS    (BINS),
        .NW      (NW),
        .BW      (BW)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .adv    (accept),
        .neuron (cur_neuron),
        .bin    (cur_bin),
        .kind   (cur_kind)
    );

    sbc_count_mem #(
        .NEURONS (NEURONS),
        .STEPS   (STEPS),
        .NW      (NW),
        .CW      (CW)
    ) u_mem (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (accept),
        .addr   (cur_neuron),
        .bit_in (in_bit),
        .kind   (cur_kind),
        .sum    (sum)
    );

    sbc_out_stage #(
        .NEURONS (NEURONS),
        .STEPS   (STEPS),
        .BINS    (BINS),
        .NW      (NW),
        .BW      (BW),
        .CW      (CW)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (accept && (cur_kind == STEP_CLOSE)),
        .count_in   (sum),
        .neuron_in  (cur_neuron),
        .bin_in     (cur_bin),
        .out_ready  (out_ready),
        .space      (space),
        .out_valid  (out_valid),
        .out_count  (out_count),
        .out_neuron (out_neuron),
        .out_bin    (out_bin),
        .frame_done (frame_done)
    );

    // R10: an emitted count never exceeds the bin length
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_count <= CW'(STEPS));
    // R6: input is stalled while a record waits on the consumer
    a_r6_stall_input: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
    // R4: a closing beat that is accepted presents its record next cycle
    a_r4_emit_next: assert property (@(posedge clk) disable iff (rst)
        accept && (cur_kind == STEP_CLOSE) |=> out_valid && (out_neuron == $past(cur_neuron)));
    // R1: nothing is presented in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !frame_done);

endmodule

// File: tb/sim_spike_bin_counter.sv
`timescale 1ns/100ps
module sim_spike_bin_counter;
    localparam int N = 4;
    localparam int S = 3;
    localparam int B = 2;
    localparam int FRAME = N * S * B;

    // bit 25: stall the consumer, bit 24: idle gaps, bits 23:0: one bit per beat
    localparam logic [25:0] VECS [6] = '{
        26'h0_000000, 26'h0_FFFFFF, 26'h1_A5A5A5,
        26'h2_123456, 26'h3_F0F00F, 26'h2_8C31E7
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready;
    logic out_ready = 1'b1;
    logic out_valid;
    logic [1:0] out_count;
    logic [1:0] out_neuron;
    logic [0:0] out_bin;
    logic frame_done;

    int total = 0;
    int bad = 0;
    int expq[$];
    int acc [N];
    int bn = 0, bs = 0, bb = 0;
    bit prev_final = 1'b0;
    int cyc = 0;

    always #2 clk = ~clk;

    spike_bin_counter #(.NEURONS(N), .STEPS(S), .BINS(B)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
        .out_count(out_count), .out_neuron(out_neuron), .out_bin(out_bin),
        .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic model_clear();
        expq.delete();
        for (int i = 0; i < N; i++) acc[i] = 0;
        bn = 0; bs = 0; bb = 0;
    endtask

    // bench model of R2/R3/R5/R7: neuron-major beats, record on closing step
    task automatic model_beat(input logic b);
        acc[bn] += int'(b);
        if (bs == S - 1) begin
            expq.push_back(bb * 256 + bn * 16 + acc[bn]);
            acc[bn] = 0;
        end
        if (bn == N - 1) begin
            bn = 0;
            if (bs == S - 1) begin
                bs = 0;
                bb = (bb == B - 1) ? 0 : bb + 1;
            end else bs++;
        end else bn++;
    endtask

    task automatic drive_beat(input logic b, input bit gap, input bit stall, input int idx);
        @(negedge clk); #0.2;
        if (gap) begin
            in_valid = 1'b0;
            @(negedge clk); #0.2;  // R9: idle cycle between beats
        end
        in_valid  = 1'b1;
        in_bit    = b;
        out_ready = stall ? (idx % 3 != 1) : 1'b1;
        #0.2;
        while (!in_ready) begin
            @(negedge clk); #0.2;
            out_ready = 1'b1;
            #0.2;
        end
        @(posedge clk);
        model_beat(b);
    endtask

    task automatic go_idle(input int cycles);
        @(negedge clk); #0.2;
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic drive_frame(input logic [23:0] pat, input bit gaps, input bit stall);
        for (int j = 0; j < FRAME; j++) drive_beat(pat[j], gaps && (j % 5 == 2), stall, j);
    endtask

    // record and frame-done monitor, sampled between edges
    always @(negedge clk) begin
        #1;
        if (rst) begin
            prev_final = 1'b0;
        end else begin
            if (prev_final) chk(frame_done == 1'b1, "R8 frame_done after final record", int'(frame_done), 1);
            else if (frame_done) chk(1'b0, "R8 stray frame_done", 1, 0);
            prev_final = out_valid && out_ready && (out_neuron == 2'(N - 1)) && (out_bin == 1'(B - 1));
            if (out_valid && out_ready) begin
                int act;
                act = int'(out_bin) * 256 + int'(out_neuron) * 16 + int'(out_count);
                if (expq.size() == 0) chk(1'b0, "R4 unexpected record", act, -1);
                else begin
                    int e;
                    e = expq.pop_front();
                    chk(act == e, "R3/R4/R7 record bin*256+neuron*16+count", act, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        #0.2 rst = 1'b0;
        @(negedge clk); #1;
        chk(frame_done == 1'b0 && out_valid == 1'b0, "R1 quiet after reset",
            int'(frame_done) + int'(out_valid), 0);

        // table walk: R2, R3, R5, R7, R8, R9, R10
        foreach (VECS[k]) begin
            drive_frame(VECS[k][23:0], VECS[k][24], VECS[k][25]);
        end
        go_idle(4);
        chk(expq.size() == 0, "R4 all table records emitted", expq.size(), 0);

        // R6: consumer stalls exactly on the first closing beat
        for (int j = 0; j < 2 * N + 1; j++) begin
            @(negedge clk); #0.2;
            in_valid  = 1'b1;
            in_bit    = 1'b1;
            out_ready = 1'b0;
            #0.2;
            while (!in_ready) begin @(negedge clk); #0.4; end
            @(posedge clk);
            model_beat(1'b1);
        end
        @(negedge clk); #0.2;
        in_bit = 1'b0;   // next beat waits while record is held
        for (int w = 0; w < 4; w++) begin
            @(negedge clk); #1;
            chk(in_ready == 1'b0, "R6 in_ready low while stalled", int'(in_ready), 0);
            chk(out_valid && out_count == 2'd3 && out_neuron == 2'd0, "R6 held record",
                int'(out_count), 3);
        end
        @(negedge clk); #0.2;
        in_valid = 1'b0;
        out_ready = 1'b1;
        for (int j = 2 * N + 1; j < FRAME; j++) drive_beat(1'b0, 1'b0, 1'b0, j);
        go_idle(4);
        chk(expq.size() == 0, "R6 stalled frame drained", expq.size(), 0);

        // R1/R5: reset part-way through a bin with non-zero counts
        for (int j = 0; j < N + 1; j++) drive_beat(1'b1, 1'b0, 1'b0, j);
        @(negedge clk); #0.2;
        in_valid = 1'b0;
        rst = 1'b1;
        model_clear();
        @(negedge clk); #1;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 mid-frame reset state",
            int'(out_valid), 0);
        #0.2 rst = 1'b0;
        drive_frame(24'h000000, 1'b0, 1'b0);
        go_idle(4);
        chk(expq.size() == 0, "R1 records after mid-frame reset", expq.size(), 0);

        finish_run();
    end
endmodule